// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Matcher and Dispatcher

This block takes one interprocessor interrupt command at a time and works out which of `NCORE` cores receive it. A command carries a vector, a delivery mode, a physical/logical destination selector, a two-bit shorthand, trigger and level flags, an 8-bit destination and the index of the sending core. Each core holds an 8-bit physical ID, an 8-bit logical ID, a 4-bit logical format code and an enable bit in a small configuration file. These are written through a simple write port.

For any delivery mode other than lowest-priority, the block returns the mask of matching, enabled cores one cycle after it accepts the command. For lowest-priority delivery it picks one enabled candidate by round robin. It scans one core per cycle, starting just past the core it chose last time, and returns a one-hot mask. If no core qualifies it returns an empty mask. The vector, mode, trigger and level come back with the mask. `cmd_ready` is low while a command is being resolved, and commands presented then are dropped.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, core i has physical ID 2*i, logical ID 0, format code 4'hF (flat) and is enabled. The next lowest-priority search starts at core 0.
- R2: With shorthand 0 and `cmd_logical`=0, a core matches when `cmd_dest` equals its physical ID or `cmd_dest` is 8'hFF.
- R3: With shorthand 0, `cmd_logical`=1 and format 4'hF (flat), a core matches when its logical ID AND `cmd_dest` is nonzero.
- R4: With shorthand 0, `cmd_logical`=1 and format 4'h0 (cluster), a core matches when the upper nibbles of its logical ID and `cmd_dest` are equal and their lower nibbles share a set bit.
- R5: With shorthand 0 and `cmd_logical`=1, a core whose format code is neither 4'hF nor 4'h0 never matches.
- R6: Shorthand 1 selects only core `cmd_src`. Shorthand 2 selects every core. Shorthand 3 selects every core except `cmd_src`. In all three, `cmd_dest` and `cmd_logical` are ignored.
- R7: For `cmd_mode` other than 1, `out_valid` is high in the cycle after acceptance, and `out_mask` equals the matching cores that are enabled.
- R8: For `cmd_mode`=1 (lowest priority), the first enabled matching core found scanning from (last chosen + 1) mod NCORE, with wrap, is returned one-hot. If it lies k steps from the start, `out_valid` rises k+2 cycles after acceptance. That core becomes the last chosen.
- R9: For `cmd_mode`=1 with no enabled matching core, `out_valid` rises NCORE+1 cycles after acceptance with `out_mask`=0, and the last chosen core is unchanged.
- R10: `out_valid` is a single-cycle pulse. `cmd_ready` is low from the cycle after acceptance until the result has been presented, and a command presented while `cmd_ready` is low has no effect.
- R11: `out_vector`, `out_mode`, `out_trigger` and `out_level` repeat the fields of the accepted command while `out_valid` is high.
- R12: A write with `cfg_we`=1 sets a field of core `cfg_core`, chosen by `cfg_field`: 0 physical ID, 1 logical ID, 2 format code (`cfg_wdata[3:0]`), 3 enable (`cfg_wdata[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_mode | input | 3 | Delivery mode, 1 = lowest priority |
| cmd_logical | input | 1 | 0 physical, 1 logical destination |
| cmd_shorthand | input | 2 | 0 dest field, 1 self, 2 all, 3 all but self |
| cmd_trigger | input | 1 | Trigger flag, carried through |
| cmd_level | input | 1 | Level flag, carried through |
| cmd_dest | input | 8 | Destination field |
| cmd_src | input | IW | Index of the sending core |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core | input | IW | Core written |
| cfg_field | input | 2 | Field written |
| cfg_wdata | input | 8 | Write data |
| out_valid | output | 1 | Result pulse |
| out_mask | output | NCORE | Target cores |
| out_vector | output | 8 | Vector of the resolved command |
| out_mode | output | 3 | Mode of the resolved command |
| out_trigger | output | 1 | Trigger of the resolved command |
| out_level | output | 1 | Level of the resolved command |

## Verification
Several properties are checked on every cycle: the one-cycle result pulse, ready dropping after acceptance, a one-hot or empty mask for lowest-priority results, a bound of NCORE scan cycles, and the mask shapes for broadcast and self destinations. The exact choice made by round robin, the latency that depends on distance, the differences between flat, cluster and bad-format matching, and dropping a command presented while busy can only be shown by the bench scenarios. The bench compares those against its own model of the configuration and of the last chosen core.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int ID_W  = 8;
    localparam int FMT_W = 4;

    localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

    localparam logic [2:0] MODE_LOWEST = 3'd1;

    localparam logic [1:0] SH_DEST   = 2'd0;
    localparam logic [1:0] SH_SELF   = 2'd1;
    localparam logic [1:0] SH_ALL    = 2'd2;
    localparam logic [1:0] SH_OTHERS = 2'd3;

    localparam logic [1:0] CF_ID  = 2'd0;
    localparam logic [1:0] CF_LID = 2'd1;
    localparam logic [1:0] CF_FMT = 2'd2;
    localparam logic [1:0] CF_EN  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } disp_state_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       trigger;
        logic       level;
    } echo_t;
endpackage

// File: rtl/ipi_core_cfg.sv
module ipi_core_cfg
    import ipi_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IW-1:0]         core,
    input  logic [1:0]            field,
    input  logic [7:0]            wdata,
    output logic [NCORE*ID_W-1:0] id_flat,
    output logic [NCORE*ID_W-1:0] lid_flat,
    output logic [NCORE*FMT_W-1:0] fmt_flat,
    output logic [NCORE-1:0]      en
);
    logic [ID_W-1:0]  id_d  [NCORE];
    logic [ID_W-1:0]  id_q  [NCORE];
    logic [ID_W-1:0]  lid_d [NCORE];
    logic [ID_W-1:0]  lid_q [NCORE];
    logic [FMT_W-1:0] fmt_d [NCORE];
    logic [FMT_W-1:0] fmt_q [NCORE];
    logic [NCORE-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        for (int i = 0; i < NCORE; i++) begin
            id_d[i]  = id_q[i];
            lid_d[i] = lid_q[i];
            fmt_d[i] = fmt_q[i];
            if (we && (core == IW'(i))) begin
                case (field)
                    CF_ID:   id_d[i]  = wdata;
                    CF_LID:  lid_d[i] = wdata;
                    CF_FMT:  fmt_d[i] = wdata[FMT_W-1:0];
                    default: en_d[i]  = wdata[0];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCORE; i++) begin
                id_q[i]  <= ID_W'(2 * i);
                lid_q[i] <= '0;
                fmt_q[i] <= FMT_FLAT;
            end
            en_q <= '1;
        end else begin
            for (int i = 0; i < NCORE; i++) begin
                id_q[i]  <= id_d[i];
                lid_q[i] <= lid_d[i];
                fmt_q[i] <= fmt_d[i];
            end
            en_q <= en_d;
        end
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_flat
        assign id_flat[g*ID_W +: ID_W]    = id_q[g];
        assign lid_flat[g*ID_W +: ID_W]   = lid_q[g];
        assign fmt_flat[g*FMT_W +: FMT_W] = fmt_q[g];
    end
    assign en = en_q;
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic [NCORE*ID_W-1:0]  id_flat,
    input  logic [NCORE*ID_W-1:0]  lid_flat,
    input  logic [NCORE*FMT_W-1:0] fmt_flat,
    input  logic [1:0]             shorthand,
    input  logic                   logical,
    input  logic [7:0]             dest,
    input  logic [IW-1:0]          src,
    output logic [NCORE-1:0]       match
);
    for (genvar g = 0; g < NCORE; g++) begin : g_core
        logic [ID_W-1:0]  pid;
        logic [ID_W-1:0]  lid;
        logic [FMT_W-1:0] fmt;
        logic             phys_hit, flat_hit, clus_hit, dest_hit, is_self;

        assign pid = id_flat[g*ID_W +: ID_W];
        assign lid = lid_flat[g*ID_W +: ID_W];
        assign fmt = fmt_flat[g*FMT_W +: FMT_W];

        assign phys_hit = (dest == 8'hFF) || (dest == pid);
        assign flat_hit = (fmt == FMT_FLAT) && (|(lid & dest));
        assign clus_hit = (fmt == FMT_CLUSTER) && (lid[7:4] == dest[7:4])
                          && (|(lid[3:0] & dest[3:0]));
        assign dest_hit = logical ? (flat_hit || clus_hit) : phys_hit;
        assign is_self  = (src == IW'(g));

        always_comb begin
            case (shorthand)
                SH_DEST:  match[g] = dest_hit;
                SH_SELF:  match[g] = is_self;
                SH_ALL:   match[g] = 1'b1;
                default:  match[g] = !is_self;
            endcase
        end
    end
endmodule

// File: rtl/ipi_rr_dispatch.sv
module ipi_rr_dispatch
    import ipi_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             lowest,
    input  logic [NCORE-1:0] cand,
    output logic             ready,
    output logic             res_valid,
    output logic [NCORE-1:0] res_mask
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NCORE - 1);

    typedef struct packed {
        disp_state_e      st;
        logic             lowest;
        logic [IW-1:0]    ptr;
        logic [IW-1:0]    cnt;
        logic [IW-1:0]    last;
        logic [NCORE-1:0] cand;
        logic [NCORE-1:0] mask;
    } rr_state_t;

    rr_state_t s_d, s_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + IW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.lowest = lowest;
                    if (lowest) begin
                        s_d.st   = ST_SCAN;
                        s_d.ptr  = step(s_q.last);
                        s_d.cnt  = '0;
                        s_d.cand = cand;
                    end else begin
                        s_d.st   = ST_EMIT;
                        s_d.mask = cand;
                    end
                end
            end
            ST_SCAN: begin
                if (s_q.cand[s_q.ptr]) begin
                    s_d.mask           = '0;
                    s_d.mask[s_q.ptr]  = 1'b1;
                    s_d.last           = s_q.ptr;
                    s_d.st             = ST_EMIT;
                end else if (s_q.cnt == LAST_IDX) begin
                    s_d.mask = '0;
                    s_d.st   = ST_EMIT;
                end else begin
                    s_d.ptr = step(s_q.ptr);
                    s_d.cnt = s_q.cnt + IW'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.last   <= LAST_IDX;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready     = (s_q.st == ST_IDLE);
    assign res_valid = (s_q.st == ST_EMIT);
    assign res_mask  = s_q.mask;

    // independent scan-length counter for the R9 window
    logic [IW:0] scan_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 scan_len_q <= '0;
        else if (s_q.st == ST_SCAN) scan_len_q <= scan_len_q + 1'b1;
        else                        scan_len_q <= '0;
    end

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && s_q.lowest) |-> $onehot0(res_mask));
    p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_len_q <= (IW+1)'(NCORE));
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [7:0]       cmd_vector,
    input  logic [2:0]       cmd_mode,
    input  logic             cmd_logical,
    input  logic [1:0]       cmd_shorthand,
    input  logic             cmd_trigger,
    input  logic             cmd_level,
    input  logic [7:0]       cmd_dest,
    input  logic [IW-1:0]    cmd_src,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_core,
    input  logic [1:0]       cfg_field,
    input  logic [7:0]       cfg_wdata,
    output logic             out_valid,
    output logic [NCORE-1:0] out_mask,
    output logic [7:0]       out_vector,
    output logic [2:0]       out_mode,
    output logic             out_trigger,
    output logic             out_level
);
    logic [NCORE*ID_W-1:0]  id_flat, lid_flat;
    logic [NCORE*FMT_W-1:0] fmt_flat;
    logic [NCORE-1:0]       core_en, match;
    logic                   accept;
    echo_t                  echo_d, echo_q;

    ipi_core_cfg #(.NCORE(NCORE), .IW(IW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .core(cfg_core),
        .field(cfg_field), .wdata(cfg_wdata), .id_flat(id_flat),
        .lid_flat(lid_flat), .fmt_flat(fmt_flat), .en(core_en)
    );

    ipi_dest_match #(.NCORE(NCORE), .IW(IW)) u_match (
        .id_flat(id_flat), .lid_flat(lid_flat), .fmt_flat(fmt_flat),
        .shorthand(cmd_shorthand), .logical(cmd_logical), .dest(cmd_dest),
        .src(cmd_src), .match(match)
    );

    ipi_rr_dispatch #(.NCORE(NCORE), .IW(IW)) u_rr (
        .clk(clk), .rst_n(rst_n), .start(cmd_valid),
        .lowest(cmd_mode == MODE_LOWEST), .cand(match & core_en),
        .ready(cmd_ready), .res_valid(out_valid), .res_mask(out_mask)
    );

    assign accept = cmd_valid && cmd_ready;

    always_comb begin
        echo_d = echo_q;
        if (accept) begin
            echo_d.vector  = cmd_vector;
            echo_d.mode    = cmd_mode;
            echo_d.trigger = cmd_trigger;
            echo_d.level   = cmd_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) echo_q <= '0;
        else        echo_q <= echo_d;
    end

    assign out_vector  = echo_q.vector;
    assign out_mode    = echo_q.mode;
    assign out_trigger = echo_q.trigger;
    assign out_level   = echo_q.level;

    p_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_shorthand == SH_SELF) |-> $onehot(match));
    p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_shorthand == SH_DEST && !cmd_logical
         && cmd_dest == 8'hFF) |-> (match == '1));
endmodule

// File: tb/sim_ipi_dispatch.sv
module sim_ipi_dispatch;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_logical = 0, cmd_trigger = 0, cmd_level = 0;
    logic [7:0] cmd_vector = 0, cmd_dest = 0, cfg_wdata = 0;
    logic [2:0] cmd_mode = 0;
    logic [1:0] cmd_shorthand = 0, cfg_field = 0;
    logic [IW-1:0] cmd_src = 0, cfg_core = 0;
    logic cfg_we = 0;
    logic cmd_ready, out_valid, out_trigger, out_level;
    logic [N-1:0] out_mask;
    logic [7:0] out_vector;
    logic [2:0] out_mode;

    int checks = 0, errors = 0, cyc = 0;

    logic [7:0] b_id [N];
    logic [7:0] b_lid [N];
    logic [3:0] b_fmt [N];
    logic [N-1:0] b_en;
    int b_last;

    always #5 clk = ~clk;

    ipi_dispatch #(.NCORE(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vector(cmd_vector), .cmd_mode(cmd_mode), .cmd_logical(cmd_logical),
        .cmd_shorthand(cmd_shorthand), .cmd_trigger(cmd_trigger),
        .cmd_level(cmd_level), .cmd_dest(cmd_dest), .cmd_src(cmd_src),
        .cfg_we(cfg_we), .cfg_core(cfg_core), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_mask(out_mask),
        .out_vector(out_vector), .out_mode(out_mode),
        .out_trigger(out_trigger), .out_level(out_level)
    );

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit hit(input int i, input bit lg, input logic [1:0] sh,
                               input logic [7:0] d, input int src);
        case (sh)
            2'd1: return i == src;
            2'd2: return 1'b1;
            2'd3: return i != src;
            default: begin
                if (!lg) return (d == 8'hFF) || (d == b_id[i]);
                if (b_fmt[i] == 4'hF) return (b_lid[i] & d) != 0;
                if (b_fmt[i] == 4'h0)
                    return (b_lid[i][7:4] == d[7:4]) && ((b_lid[i][3:0] & d[3:0]) != 0);
                return 1'b0;
            end
        endcase
    endfunction

    task automatic cfg_write(input int core, input logic [1:0] f, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_core = IW'(core); cfg_field = f; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        case (f)
            2'd0: b_id[core] = v;
            2'd1: b_lid[core] = v;
            2'd2: b_fmt[core] = v[3:0];
            default: b_en[core] = v[0];
        endcase
    endtask

    // drives one command and checks result; busy_poke drives a stray command mid-scan
    task automatic run_cmd(input logic [7:0] vec, input logic [2:0] mode,
                           input bit lg, input logic [1:0] sh, input bit trg,
                           input bit lvl, input logic [7:0] d, input int src,
                           input string req, input bit busy_poke);
        logic [N-1:0] cand, emask;
        int lat, n, idx;
        bit found;
        cand = '0;
        for (int i = 0; i < N; i++) cand[i] = hit(i, lg, sh, d, src) && b_en[i];
        if (mode == 3'd1) begin
            found = 0; emask = '0; lat = N + 1;
            for (int k = 0; k < N; k++) begin
                idx = (b_last + 1 + k) % N;
                if (!found && cand[idx]) begin
                    found = 1; emask[idx] = 1'b1; lat = k + 2; b_last = idx;
                end
            end
        end else begin
            emask = cand; lat = 1;
        end
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10 ready before command", cmd_ready, 1);
        cmd_valid = 1; cmd_vector = vec; cmd_mode = mode; cmd_logical = lg;
        cmd_shorthand = sh; cmd_trigger = trg; cmd_level = lvl; cmd_dest = d;
        cmd_src = IW'(src);
        @(negedge clk);
        cmd_valid = 0;
        n = 1;
        if (busy_poke && !out_valid) begin
            chk(cmd_ready == 1'b0, "R10 busy ready low", cmd_ready, 0);
            cmd_valid = 1; cmd_vector = ~vec; cmd_mode = 3'd0; cmd_shorthand = 2'd2;
        end
        while (!out_valid && n < 20) begin
            @(negedge clk); n++;
            cmd_valid = 0;
        end
        chk(out_valid == 1'b1, {req, " result valid"}, out_valid, 1);
        chk(n == lat, {req, " latency"}, n, lat);
        chk(out_mask == emask, {req, " mask"}, out_mask, emask);
        chk(out_vector == vec && out_mode == mode && out_trigger == trg && out_level == lvl,
            "R11 echo", {out_vector, out_mode, out_trigger, out_level},
            {vec, mode, trg, lvl});
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 single pulse", out_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            b_id[i] = 8'(2 * i); b_lid[i] = 0; b_fmt[i] = 4'hF;
        end
        b_en = '1; b_last = N - 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready == 1 && out_valid == 0, "R1 reset state", {cmd_ready, out_valid}, 2'b10);

        // R1 + R2: default IDs 2*i
        for (int i = 0; i < N; i++)
            run_cmd(8'(16 + i), 3'd0, 0, 2'd0, 0, 1, 8'(2 * i), 0, "R1 R2 default id", 0);
        run_cmd(8'h30, 3'd0, 0, 2'd0, 1, 0, 8'hFF, 0, "R2 broadcast", 0);
        run_cmd(8'h31, 3'd0, 0, 2'd0, 0, 0, 8'h03, 0, "R2 odd id no hit", 0);
        // R1: logical IDs zero under flat format
        run_cmd(8'h32, 3'd0, 1, 2'd0, 0, 0, 8'hFF, 0, "R1 R3 lid zero", 0);
        // R12 + R3 flat
        for (int i = 0; i < N; i++) cfg_write(i, 2'd1, 8'(1 << i));
        run_cmd(8'h40, 3'd0, 1, 2'd0, 0, 0, 8'h24, 0, "R3 flat", 0);
        // R4 cluster
        cfg_write(1, 2'd2, 8'h00); cfg_write(1, 2'd1, 8'h53);
        cfg_write(2, 2'd2, 8'h00); cfg_write(2, 2'd1, 8'h61);
        cfg_write(3, 2'd2, 8'h00); cfg_write(3, 2'd1, 8'h54);
        run_cmd(8'h41, 3'd0, 1, 2'd0, 0, 0, 8'h51, 0, "R4 cluster", 0);
        // R5 bad format
        cfg_write(5, 2'd2, 8'h05);
        run_cmd(8'h42, 3'd0, 1, 2'd0, 0, 0, 8'hFF, 0, "R5 bad format", 0);
        // R6 shorthands
        run_cmd(8'h50, 3'd0, 1, 2'd1, 0, 0, 8'h00, 6, "R6 self", 0);
        run_cmd(8'h51, 3'd0, 0, 2'd2, 0, 0, 8'h77, 2, "R6 all", 0);
        run_cmd(8'h52, 3'd0, 0, 2'd3, 0, 0, 8'hFF, 2, "R6 all but self", 0);
        // R12 enable, R7 masks disabled
        cfg_write(4, 2'd3, 8'h00);
        run_cmd(8'h60, 3'd4, 0, 2'd2, 0, 1, 8'h00, 0, "R7 R12 disabled core", 0);
        // R8 round robin with wrap
        run_cmd(8'h70, 3'd1, 0, 2'd2, 0, 0, 8'h00, 0, "R8 rr first", 0);
        run_cmd(8'h71, 3'd1, 0, 2'd2, 0, 0, 8'h00, 0, "R8 rr next", 0);
        run_cmd(8'h72, 3'd1, 0, 2'd1, 0, 0, 8'h00, 0, "R8 rr wrap", 1);
        run_cmd(8'h73, 3'd1, 0, 2'd0, 0, 0, 8'h0E, 0, "R8 rr skip disabled", 0);
        // R9 none qualifies
        run_cmd(8'h74, 3'd1, 0, 2'd0, 0, 0, 8'h08, 0, "R9 rr empty", 0);
        run_cmd(8'h75, 3'd1, 0, 2'd0, 0, 0, 8'h01, 0, "R9 rr empty odd", 1);
        run_cmd(8'h76, 3'd1, 0, 2'd2, 0, 0, 8'h00, 0, "R9 last kept", 0);

        // random mix
        for (int t = 0; t < 400; t++) begin
            if (($urandom % 6) == 0) begin
                int c, f;
                logic [7:0] v;
                c = $urandom % N; f = $urandom % 4; v = 8'($urandom);
                if (f == 2) v = (($urandom % 3) == 0) ? 8'h0 : ((($urandom % 2) == 0) ? 8'hF : 8'h9);
                if (f == 3) v = ($urandom % 4 == 0) ? 8'h0 : 8'h1;
                cfg_write(c, 2'(f), v);
            end
            begin
                logic [2:0] m;
                logic [7:0] d;
                int s;
                m = ($urandom % 2 == 0) ? 3'd1 : 3'($urandom);
                d = ($urandom % 2 == 0) ? b_id[$urandom % N] : 8'($urandom);
                s = $urandom % N;
                run_cmd(8'($urandom), m, 1'($urandom), 2'($urandom), 1'($urandom),
                        1'($urandom), d, s, (m == 3'd1) ? "R8 random" : "R7 random",
                        ($urandom % 5) == 0);
            end
        end
        finish_run();
    end
endmodule